// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether it is kept or discarded. Frame bytes arrive one per beat, in wire order, with a start marker on the first beat and an end marker on the last. While the first six bytes (the destination address) stream past, the block compares them against two programmable station addresses and the broadcast address. In the same pass it folds the address into a 6-bit index for a 64-bit group table.

Once the end marker arrives, the block also knows the frame length. One clock later it emits a single verdict: a valid strobe together with an accept flag. A 32-bit write port loads the station addresses, the group table and a receive control word. Configuration written while a frame is in flight is held back and applied from the next frame start. Each frame therefore sees one consistent setting.

Top module: `dafilt_top`

## Requirements
- R1: Word writes are decoded from byte offset `cfg_addr[4:2]`. Station A low word is at 0x00 and its high word at 0x04. Station B is at 0x08/0x0C, the group table low/high words are at 0x10/0x14, and the control word is at 0x1C. In each station address, destination byte k is bits 8k+7:8k of the low word for k=0..3, and bits 8(k-4)+7:8(k-4) of the high word for k=4,5.
- R2: Control bit 0 enables exact matching against station A, and control bit 1 enables it against station B. A frame whose six destination bytes equal an enabled station address is accepted.
- R3: With control bit 3 set, a destination of all ones is accepted. With it clear, broadcast gives no acceptance by itself.
- R4: The hash is computed over the address bits a[n], with n = 8*byte + bit. Hash bit j is the XOR of all a[n] with n mod 6 = j. Hash values 0..31 select that bit of the low table word, and values 32..63 select bit (hash-32) of the high word. A set bit accepts a group address.
- R5: Bit 0 of destination byte 0 marks a group address. When it is 0 and control bit 2 is 0, the table lookup cannot accept. When control bit 2 is 1, individual addresses are also looked up.
- R6: A frame is accepted when any enabled check passes (station A, station B, broadcast, table).
- R7: A frame of fewer than 12 bytes, counted from the start beat through the end beat, is always dropped.
- R8: Each framed end beat produces exactly one verdict. `vrd_valid` is high for the single cycle after the clock edge that takes the end beat, and `vrd_accept` is never high without `vrd_valid`.
- R9: A configuration write during a frame does not change that frame's verdict. It applies from the next start beat onward, including to that start beat itself.
- R10: After reset all registers are zero, `vrd_valid` is low, and every frame is dropped.
- R11: Beats with `rx_valid` high outside a frame (no start seen) are ignored and give no verdict. A start beat in the middle of a frame restarts the evaluation from that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Byte offset of the written word |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | A frame byte is present |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte, wire order |
| vrd_valid | output | 1 | One-cycle verdict strobe |
| vrd_accept | output | 1 | Frame accepted (qualified by vrd_valid) |

## Verification
The assertions check, on every cycle, the framing side of the block:

- `vrd_valid` only ever follows a framed end beat.
- `vrd_accept` never appears without `vrd_valid`.
- An accepted frame always had at least 12 bytes, measured by the checker's own counter.
- Reset leaves the strobe low.

The address logic can only be shown by the bench scenarios. These cover the station byte ordering, broadcast gating, the hash fold across all 64 table positions, individual-address hashing, and the deferral of mid-frame configuration writes.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int HASH_W     = 6;
    localparam int GTAB_BITS  = 1 << HASH_W;
    localparam int WORD_W     = 32;

    // word index = byte offset [4:2]
    localparam logic [2:0] WI_STA_LO  = 3'd0;
    localparam logic [2:0] WI_STA_HI  = 3'd1;
    localparam logic [2:0] WI_STB_LO  = 3'd2;
    localparam logic [2:0] WI_STB_HI  = 3'd3;
    localparam logic [2:0] WI_GTAB_LO = 3'd4;
    localparam logic [2:0] WI_GTAB_HI = 3'd5;
    localparam logic [2:0] WI_CTRL    = 3'd7;

    // control bit positions
    localparam int CB_STA      = 0;
    localparam int CB_STB      = 1;
    localparam int CB_HASH_IND = 2;
    localparam int CB_BCAST    = 3;
    localparam int CTRL_W      = 4;

    typedef struct packed {
        logic [ADDR_W-1:0]    sta;
        logic [ADDR_W-1:0]    stb;
        logic [GTAB_BITS-1:0] gtab;
        logic [CTRL_W-1:0]    ctrl;
    } filt_cfg_t;

    // Fold one address byte into the hash; byte bit i lands on
    // hash bit (phase + i) mod HASH_W.
    function automatic logic [HASH_W-1:0] fold_byte(input logic [7:0] b,
                                                    input int unsigned phase);
        logic [HASH_W-1:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            r[(phase + i) % HASH_W] = r[(phase + i) % HASH_W] ^ b[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
    import dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              frame_start,
    output filt_cfg_t         cfg_eff
);

    typedef struct packed {
        filt_cfg_t shadow;
        filt_cfg_t active;
    } regs_t;

    regs_t rg_d, rg_q;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[WORD_W-1:16], cfg_addr[1:0]};

    always_comb begin
        rg_d = rg_q;
        if (cfg_we) begin
            unique case (cfg_addr[4:2])
                WI_STA_LO:  rg_d.shadow.sta[31:0]               = cfg_wdata;
                WI_STA_HI:  rg_d.shadow.sta[ADDR_W-1:32]        = cfg_wdata[ADDR_W-33:0];
                WI_STB_LO:  rg_d.shadow.stb[31:0]               = cfg_wdata;
                WI_STB_HI:  rg_d.shadow.stb[ADDR_W-1:32]        = cfg_wdata[ADDR_W-33:0];
                WI_GTAB_LO: rg_d.shadow.gtab[WORD_W-1:0]        = cfg_wdata;
                WI_GTAB_HI: rg_d.shadow.gtab[GTAB_BITS-1:WORD_W] = cfg_wdata;
                WI_CTRL:    rg_d.shadow.ctrl                    = cfg_wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
        // snapshot pending configuration at the start of every frame
        if (frame_start) begin
            rg_d.active = rg_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    // the start beat itself already evaluates against the new snapshot
    assign cfg_eff = frame_start ? rg_q.shadow : rg_q.active;

endmodule

// File: rtl/dafilt_accum.sv
module dafilt_accum
    import dafilt_pkg::*;
#(
    parameter int MIN_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  filt_cfg_t         cfg,
    output logic              frame_start,
    output logic              frame_end,
    output logic              hit_sta,
    output logic              hit_stb,
    output logic              hit_bcast,
    output logic              is_group,
    output logic [HASH_W-1:0] hash,
    output logic              long_enough
);

    localparam int CNT_W = $clog2(MIN_LEN + 1);
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LEN);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(ADDR_BYTES);

    typedef struct packed {
        logic              in_frame;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic              eq_a;
        logic              eq_b;
        logic              eq_bc;
        logic              grp;
        logic [HASH_W-1:0] hash;
    } acc_t;

    localparam acc_t ACC_INIT = '{in_frame: 1'b0, cnt: '0, idx: '0,
                                  eq_a: 1'b1, eq_b: 1'b1, eq_bc: 1'b1,
                                  grp: 1'b0, hash: '0};

    acc_t ac_d, ac_q;
    acc_t base;
    logic beat_ok;
    int   bpos;

    assign beat_ok     = rx_valid && (rx_sof || ac_q.in_frame);
    assign frame_start = rx_valid && rx_sof;
    assign frame_end   = beat_ok && rx_eof;

    always_comb begin
        base = rx_sof ? ACC_INIT : ac_q;
        ac_d = ac_q;
        bpos = 8 * int'(base.idx);
        if (beat_ok) begin
            ac_d          = base;
            ac_d.in_frame = !rx_eof;
            if (base.cnt != CNT_MAX) begin
                ac_d.cnt = base.cnt + 1'b1;
            end
            if (base.idx != IDX_MAX) begin
                ac_d.idx   = base.idx + 1'b1;
                ac_d.eq_a  = base.eq_a  && (rx_data == cfg.sta[bpos +: 8]);
                ac_d.eq_b  = base.eq_b  && (rx_data == cfg.stb[bpos +: 8]);
                ac_d.eq_bc = base.eq_bc && (rx_data == 8'hFF);
                ac_d.hash  = base.hash ^ fold_byte(rx_data, (8 * int'(base.idx)) % HASH_W);
                if (base.idx == '0) begin
                    ac_d.grp = rx_data[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q <= ACC_INIT;
        end else begin
            ac_q <= ac_d;
        end
    end

    // flags including the current beat, consumed on the end beat
    assign hit_sta     = ac_d.eq_a  && (ac_d.idx == IDX_MAX);
    assign hit_stb     = ac_d.eq_b  && (ac_d.idx == IDX_MAX);
    assign hit_bcast   = ac_d.eq_bc && (ac_d.idx == IDX_MAX);
    assign is_group    = ac_d.grp;
    assign hash        = ac_d.hash;
    assign long_enough = (ac_d.cnt == CNT_MAX);

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
    import dafilt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              hit_sta,
    input  logic              hit_stb,
    input  logic              hit_bcast,
    input  logic              is_group,
    input  logic [HASH_W-1:0] hash,
    input  logic              long_enough,
    input  filt_cfg_t         cfg,
    output logic              vrd_valid,
    output logic              vrd_accept
);

    typedef struct packed {
        logic valid;
        logic accept;
    } vrd_t;

    vrd_t vd_d, vd_q;
    logic tab_hit;
    logic any_hit;

    always_comb begin
        tab_hit = cfg.gtab[hash] && (is_group || cfg.ctrl[CB_HASH_IND]);
        any_hit = (hit_sta   && cfg.ctrl[CB_STA])
               || (hit_stb   && cfg.ctrl[CB_STB])
               || (hit_bcast && cfg.ctrl[CB_BCAST])
               || tab_hit;
        vd_d.valid  = frame_end;
        vd_d.accept = frame_end && long_enough && any_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign vrd_valid  = vd_q.valid;
    assign vrd_accept = vd_q.accept;

endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
    import dafilt_pkg::*;
#(
    parameter int MIN_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              vrd_valid,
    output logic              vrd_accept
);

    filt_cfg_t         cfg_eff;
    logic              frame_start;
    logic              frame_end;
    logic              hit_sta;
    logic              hit_stb;
    logic              hit_bcast;
    logic              is_group;
    logic [HASH_W-1:0] hash;
    logic              long_enough;

    dafilt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .cfg_eff     (cfg_eff)
    );

    dafilt_accum #(.MIN_LEN(MIN_LEN)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .rx_data     (rx_data),
        .cfg         (cfg_eff),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .hit_sta     (hit_sta),
        .hit_stb     (hit_stb),
        .hit_bcast   (hit_bcast),
        .is_group    (is_group),
        .hash        (hash),
        .long_enough (long_enough)
    );

    dafilt_decide u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end   (frame_end),
        .hit_sta     (hit_sta),
        .hit_stb     (hit_stb),
        .hit_bcast   (hit_bcast),
        .is_group    (is_group),
        .hash        (hash),
        .long_enough (long_enough),
        .cfg         (cfg_eff),
        .vrd_valid   (vrd_valid),
        .vrd_accept  (vrd_accept)
    );

endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk #(
    parameter int MIN_LEN = 12
) (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_sof,
    input logic rx_eof,
    input logic vrd_valid,
    input logic vrd_accept
);

    logic        in_frm;
    logic [15:0] len_q;
    logic [15:0] len_now;
    logic [15:0] last_len;
    logic        framed_end;

    assign framed_end = rx_valid && rx_eof && (rx_sof || in_frm);
    assign len_now    = rx_sof ? 16'd1 : ((len_q == 16'hFFFF) ? len_q : len_q + 16'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frm   <= 1'b0;
            len_q    <= '0;
            last_len <= '0;
        end else if (rx_valid && (rx_sof || in_frm)) begin
            in_frm <= !rx_eof;
            len_q  <= len_now;
            if (rx_eof) begin
                last_len <= len_now;
            end
        end
    end

    // R8: a verdict only follows a framed end beat
    a_r8_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_valid |-> $past(framed_end));

    // R8: every framed end beat yields a verdict next cycle
    a_r8_end_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        framed_end |=> vrd_valid);

    // R8: accept is qualified by valid
    a_r8_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_accept |-> vrd_valid);

    // R7: accepted frames are long enough
    a_r7_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_accept |-> (last_len >= 16'(MIN_LEN)));

    // R10: reset keeps the strobe low
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !vrd_valid);

endmodule

bind dafilt_top dafilt_chk #(.MIN_LEN(MIN_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .rx_eof     (rx_eof),
    .vrd_valid  (vrd_valid),
    .vrd_accept (vrd_accept)
);

// File: tb/sim_dafilt_top.sv
module sim_dafilt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        vrd_valid;
    logic        vrd_accept;

    int n_chk = 0;
    int n_err = 0;

    // bench view of the configuration (pending and per-frame)
    logic [47:0] sh_sta = '0, sh_stb = '0, ac_sta, ac_stb;
    logic [63:0] sh_gt = '0, ac_gt;
    logic [3:0]  sh_ctl = '0, ac_ctl;
    logic [47:0] lfsr = 48'h5A3C_96E1_07B4;

    always #10 clk = ~clk;

    dafilt_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .vrd_valid(vrd_valid),
        .vrd_accept(vrd_accept)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int n = 0; n < 48; n++) h[n % 6] = h[n % 6] ^ a[n];
        return h;
    endfunction

    function automatic bit model(input logic [47:0] a, input int len);
        bit tab;
        tab = ac_gt[hash_of(a)] && (a[0] || ac_ctl[2]);
        return (len >= 12) && ((ac_ctl[0] && a == ac_sta) || (ac_ctl[1] && a == ac_stb)
                            || (ac_ctl[3] && a == 48'hFFFF_FFFF_FFFF) || tab);
    endfunction

    function automatic logic [47:0] next_rand();
        lfsr = {lfsr[46:0], lfsr[47] ^ lfsr[46] ^ lfsr[20] ^ lfsr[19]};
        lfsr = lfsr ^ (lfsr << 13) ^ 48'h1F;
        return lfsr;
    endfunction

    task automatic shadow_upd(input logic [4:0] ad, input logic [31:0] d);
        case (ad[4:2])
            3'd0: sh_sta[31:0]  = d;
            3'd1: sh_sta[47:32] = d[15:0];
            3'd2: sh_stb[31:0]  = d;
            3'd3: sh_stb[47:32] = d[15:0];
            3'd4: sh_gt[31:0]   = d;
            3'd5: sh_gt[63:32]  = d;
            3'd7: sh_ctl        = d[3:0];
            default: ;
        endcase
    endtask

    task automatic wr(input logic [4:0] ad, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        shadow_upd(ad, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_sta(input logic [47:0] a); wr(5'h00, a[31:0]); wr(5'h04, {16'h0, a[47:32]}); endtask
    task automatic set_stb(input logic [47:0] a); wr(5'h08, a[31:0]); wr(5'h0C, {16'h0, a[47:32]}); endtask
    task automatic set_gt(input logic [63:0] g); wr(5'h10, g[31:0]); wr(5'h14, g[63:32]); endtask

    // send one frame, optionally writing config on its third beat
    task automatic send(input logic [47:0] a, input int len, input string tag,
                        input bit mid, input logic [4:0] mad, input logic [31:0] md);
        bit exp;
        ac_sta = sh_sta; ac_stb = sh_stb; ac_gt = sh_gt; ac_ctl = sh_ctl;
        exp = model(a, len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data  = (i < 6) ? a[8*i +: 8] : 8'(i * 7 + 3);
            if (mid && i == 2) begin
                cfg_we = 1'b1; cfg_addr = mad; cfg_wdata = md; shadow_upd(mad, md);
            end else begin
                cfg_we = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; cfg_we = 1'b0;
        chk(vrd_valid == 1'b1, "R8 valid pulse", 64'(vrd_valid), 64'd1);
        chk(vrd_accept == exp, tag, 64'(vrd_accept), 64'(exp));
        @(negedge clk);
        chk(vrd_valid == 1'b0, "R8 single cycle", 64'(vrd_valid), 64'd0);
    endtask

    task automatic sendn(input logic [47:0] a, input int len, input string tag);
        send(a, len, tag, 1'b0, 5'h0, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        logic [47:0] a, sa, sb;
        repeat (3) @(negedge clk);
        chk(vrd_valid == 1'b0, "R10 valid low in reset", 64'(vrd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vrd_valid == 1'b0, "R10 valid low after reset", 64'(vrd_valid), 64'd0);
        sendn(48'hFFFF_FFFF_FFFF, 14, "R10 broadcast dropped after reset");
        sendn(48'h0000_0000_0001, 14, "R10 group dropped after reset");
        sendn(48'h0000_0000_0000, 20, "R10 zero address dropped after reset");

        // station addresses, R1 R2 R3 R6
        sa = 48'h0A1B_2C3D_4E50;
        sb = 48'h6172_8394_A5B6;
        set_sta(sa); set_stb(sb);
        wr(5'h1C, 32'h0000_000B);
        sendn(sa, 16, "R2 station A exact");
        sendn(sb, 16, "R2 station B exact");
        sendn(48'hFFFF_FFFF_FFFF, 12, "R3 broadcast enabled");
        for (int k = 0; k < 6; k++) begin
            a = sa ^ (48'h04 << (8 * k));
            sendn(a, 16, "R1 station byte mismatch");
        end
        sendn({sa[7:0], sa[15:8], sa[23:16], sa[31:24], sa[39:32], sa[47:40]}, 16,
              "R1 byte order reversed");
        wr(5'h1C, 32'h0000_0001);
        sendn(sb, 16, "R2 station B disabled");
        sendn(48'hFFFF_FFFF_FFFF, 16, "R3 broadcast disabled");
        sendn(sa, 16, "R6 station A alone");
        wr(5'h1C, 32'h0000_0002);
        sendn(sa, 16, "R2 station A disabled");

        // hash sweep, R4
        wr(5'h1C, 32'h0);
        for (int j = 0; j < 64; j++) begin
            set_gt(64'd1 << j);
            for (int t = 0; t < 3; t++) begin
                a = next_rand();
                a[0] = 1'b1;
                if (t == 0) a[47:42] = a[47:42] ^ (hash_of(a) ^ 6'(j));
                sendn(a, 13, "R4 group hash lookup");
            end
        end

        // individual hashing, R5
        set_gt('1);
        sendn(48'h1234_5678_9AB0, 14, "R5 individual not hashed");
        sendn(48'h1234_5678_9AB1, 14, "R5 group hashed");
        wr(5'h1C, 32'h0000_0004);
        sendn(48'h1234_5678_9AB0, 14, "R5 individual hashed when enabled");
        set_gt(64'h0);
        sendn(48'h1234_5678_9AB0, 14, "R5 individual miss on empty table");

        // length, R7
        wr(5'h1C, 32'h0000_0008);
        for (int L = 1; L <= 14; L++) sendn(48'hFFFF_FFFF_FFFF, L, "R7 length threshold");

        // mid-frame write, R9
        send(48'hFFFF_FFFF_FFFF, 14, "R9 old config kept", 1'b1, 5'h1C, 32'h0);
        sendn(48'hFFFF_FFFF_FFFF, 14, "R9 new config applied");
        send(sa, 14, "R9 station write deferred", 1'b1, 5'h1C, 32'h1);
        sendn(sa, 14, "R9 station enabled next frame");

        // unframed beats and restart, R11
        wr(5'h1C, 32'h0000_0008);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 3); rx_data = 8'hFF;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        chk(vrd_valid == 1'b0, "R11 unframed end ignored", 64'(vrd_valid), 64'd0);
        @(negedge clk);
        chk(vrd_valid == 1'b0, "R11 no late verdict", 64'(vrd_valid), 64'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_data = 8'h22;
        end
        sendn(48'hFFFF_FFFF_FFFF, 12, "R11 restart on new start beat");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule